// File: doc/BRIEF.md
# Gated Countdown System Timer

This block is a one-shot countdown timer on a small synchronous register bus. Software loads a tick value and the block counts it down one step per clock. When the count reaches zero, the block sets a pending flag and holds the count at zero. A level interrupt is raised while that flag is pending and interrupts are enabled.

A single run bit in the control register acts as the timer's clock gate. Nothing else in the block moves while that bit is low. The counter halts, loads of new tick values are refused, and writes to the interrupt-enable and acknowledge fields are discarded. The gate is judged by the run bit as it stood before the write. As a result, a timer that is stopped must first be started with a run-only write before an acknowledge can take hold. An acknowledge must also carry the run bit, because a write with run low turns the gate off.

For a clean shutdown, software writes run, then run with acknowledge, then all zeros. A pending flag left standing survives the final zero write.

Top module: `systick_timer`

## Requirements
- R1: While reset is high and in the first cycle after it, the control bits, the counter and the pending flag are all zero, and irq_o is low.
- R2: The control register is at address 0. Its bit 0 (run) takes the written value on every control write. The counter decrements only while run is 1 and holds its value while run is 0.
- R3: A write to address 1 (tick) loads the counter only if run was already 1 before the write. Otherwise the write is ignored, and reading address 1 still returns the old count.
- R4: Reading address 1 returns the count. After a tick value N (N ≥ 1) is loaded, the count falls by one per running cycle. On the edge where it goes from 1 to 0, the pending flag is set and the count then stays at 0.
- R5: The control bit 1 (interrupt enable) and the bit 2 (acknowledge) act only if run was 1 before the write. A write of run, enable and acknowledge together while stopped sets run only. It leaves the enable bit and the pending flag unchanged.
- R6: An acknowledge clears the pending flag only when the same write also carries run = 1. A write with acknowledge set and run clear stops the timer and leaves the flag pending.
- R7: Writing zero to the control register stops the timer and keeps a pending flag set.
- R8: irq_o is high exactly when the interrupt enable bit and the pending flag are both 1. Reading address 2 returns the pending flag in bit 0, whatever the enable bit is.
- R9: Reading address 0 returns run in bit 0 and interrupt enable in bit 1, as last accepted. Bit 2 and all higher bits read 0. Address 3 reads 0.
- R10: When an acknowledge and the 1-to-0 expiry fall in the same cycle, the expiry wins and the flag stays pending.
- R11: When a tick load and a decrement fall in the same cycle, the load wins. If the count stood at 1, no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
Two kinds of event can land on the same edge. One is an acknowledge arriving as the count expires. The other is a new tick load arriving as the counter decrements from 1. The bench provokes both by loading a short tick value and then issuing the acknowledge or the reload after a delay that sweeps across the expiry cycle. A behavioural model applies the stated priorities: expiry over acknowledge, and load over decrement. The readback and irq_o are compared with the model on every clock.

// File: rtl/systick_pkg.sv
package systick_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_TICK = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int BIT_RUN = 0;
    localparam int BIT_IEN = 1;
    localparam int BIT_ACK = 2;

    typedef struct packed {
        logic run;
        logic ien;
    } ctrl_t;

    typedef struct packed {
        logic run;
        logic ien;
        logic ack;
    } ctrl_wr_t;

    function automatic reg_sel_e decode_sel(input int unsigned a);
        case (a)
            0:       return SEL_CTRL;
            1:       return SEL_TICK;
            2:       return SEL_STAT;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/systick_ctrl.sv
module systick_ctrl
    import systick_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ctrl_wr,
    input  ctrl_wr_t wr_fields,
    input  logic     tick_wr,
    output ctrl_t    ctrl,
    output logic     ack_ok,
    output logic     load_ok
);

    // gate uses run as it stood before this write
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.run <= wr_fields.run;
            if (ctrl.run) begin
                ctrl.ien <= wr_fields.ien;
            end
        end
    end

    always_comb begin
        ack_ok  = ctrl_wr && ctrl.run && wr_fields.run && wr_fields.ack;
        load_ok = tick_wr && ctrl.run;
    end

endmodule

// File: rtl/systick_counter.sv
module systick_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         expire
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (run && count != '0) begin
            count <= count - ONE;
        end
    end

    assign expire = run && !load && (count == ONE);

endmodule

// File: rtl/systick_pending.sv
module systick_pending (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic ien,
    output logic pending,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (set) begin
            pending <= 1'b1;
        end else if (clr) begin
            pending <= 1'b0;
        end
    end

    assign irq = pending && ien;

endmodule

// File: rtl/systick_timer.sv
module systick_timer
    import systick_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    reg_sel_e    sel;
    ctrl_wr_t    wr_fields;
    ctrl_t       ctrl;
    logic        ack_ok;
    logic        load_ok;
    logic        expire;
    logic        pending;
    logic [DATA_W-1:0] count;

    assign sel = decode_sel(int'(bus_addr));

    always_comb begin
        wr_fields.run = bus_wdata[BIT_RUN];
        wr_fields.ien = bus_wdata[BIT_IEN];
        wr_fields.ack = bus_wdata[BIT_ACK];
    end

    systick_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (bus_we && sel == SEL_CTRL),
        .wr_fields (wr_fields),
        .tick_wr   (bus_we && sel == SEL_TICK),
        .ctrl      (ctrl),
        .ack_ok    (ack_ok),
        .load_ok   (load_ok)
    );

    systick_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl.run),
        .load     (load_ok),
        .load_val (bus_wdata),
        .count    (count),
        .expire   (expire)
    );

    systick_pending u_pend (
        .clk     (clk),
        .rst     (rst),
        .set     (expire),
        .clr     (ack_ok),
        .ien     (ctrl.ien),
        .pending (pending),
        .irq     (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL: begin
                bus_rdata[BIT_RUN] = ctrl.run;
                bus_rdata[BIT_IEN] = ctrl.ien;
            end
            SEL_TICK: bus_rdata = count;
            SEL_STAT: bus_rdata[0] = pending;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/systick_checker.sv
module systick_checker #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              w_run,
    input logic              irq_o,
    input logic              run,
    input logic              ien,
    input logic              pending,
    input logic [DATA_W-1:0] count
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
    logic ctrl_w;
    logic tick_w;
    assign ctrl_w = bus_we && bus_addr == ADDR_W'(0);
    assign tick_w = bus_we && bus_addr == ADDR_W'(1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (count == '0 && !pending && !run && !ien && !irq_o));

    // R2
    stop_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> count == $past(count));

    // R3
    tick_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_w && !run) |=> count == $past(count));

    // R4
    expiry_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (run && count == ONE && !tick_w) |=> (pending && count == '0));

    // R5
    ien_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_w && !run) |=> (ien == $past(ien) && pending == $past(pending)));

    // R7
    stop_keeps_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_w && !w_run && pending) |=> pending);

    // R8
    irq_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        !pending |-> !irq_o);

endmodule

bind systick_timer systick_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .w_run    (bus_wdata[0]),
    .irq_o    (irq_o),
    .run      (ctrl.run),
    .ien      (ctrl.ien),
    .pending  (pending),
    .count    (count)
);

// File: tb/systick_timer_test.sv
`timescale 1ns/1ps
module systick_timer_test;

    localparam int AW = 2;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;
    string tag = "R1";

    // model state
    bit m_run = 0, m_ien = 0, m_pend = 0;
    int unsigned m_cnt = 0;

    always #2.5 clk = ~clk;

    systick_timer #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        bit old_run, expire, load, ack;
        if (rst) begin
            m_run = 0; m_ien = 0; m_pend = 0; m_cnt = 0;
        end else begin
            old_run = m_run;
            load    = bus_we && bus_addr == 2'd1 && old_run;
            expire  = old_run && m_cnt == 1 && !load;
            ack     = bus_we && bus_addr == 2'd0 && old_run && bus_wdata[0] && bus_wdata[2];
            if (load) m_cnt = bus_wdata;
            else if (old_run && m_cnt != 0) m_cnt = m_cnt - 1;
            if (expire) m_pend = 1;
            else if (ack) m_pend = 0;
            if (bus_we && bus_addr == 2'd0) begin
                if (old_run) m_ien = bus_wdata[1];
                m_run = bus_wdata[0];
            end
        end
    end

    always @(negedge clk) begin
        logic [DW-1:0] exp_rd;
        logic exp_irq;
        cycles++;
        case (bus_addr)
            2'd0: exp_rd = {30'd0, m_ien, m_run};
            2'd1: exp_rd = m_cnt;
            2'd2: exp_rd = {31'd0, m_pend};
            default: exp_rd = '0;
        endcase
        exp_irq = m_ien & m_pend;
        compared++;
        if (bus_rdata !== exp_rd || irq_o !== exp_irq) begin
            mismatched++;
            $display("FAIL %s addr=%0d rdata=%0h irq=%b expected rdata=%0h irq=%b",
                     tag, bus_addr, bus_rdata, irq_o, exp_rd, exp_irq);
        end
        if (cycles > 100000 && !done) begin
            mismatched++;
            $display("FAIL watchdog expired in %s", tag);
            finish_run();
        end
    end

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [AW-1:0] a, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            bus_we = 1'b0; bus_addr = a; bus_wdata = '0;
        end
    endtask

    task automatic shutdown();
        wr(2'd0, 32'h1); wr(2'd0, 32'h5); wr(2'd0, 32'h0); rd(2'd2, 1);
    endtask

    initial begin
        tag = "R1 reset";
        rd(2'd0, 2); rd(2'd1, 1); rd(2'd2, 1);
        @(negedge clk); #1; rst = 1'b0;
        rd(2'd0, 1); rd(2'd2, 1);

        tag = "R3 tick write while stopped";
        wr(2'd1, 32'd5); rd(2'd1, 3);

        tag = "R5 run+ien+ack from stopped";
        wr(2'd0, 32'h7); rd(2'd0, 2);

        tag = "R9 ien accepted with run";
        wr(2'd0, 32'h7); rd(2'd0, 2);

        tag = "R4 countdown to expiry";
        wr(2'd1, 32'd4); rd(2'd1, 6);
        tag = "R8 irq and status";
        rd(2'd2, 2); rd(2'd3, 1);

        tag = "R7 zero write keeps pending";
        wr(2'd0, 32'h0); rd(2'd2, 2); rd(2'd0, 1);

        tag = "R5 run+ack from stopped does not clear";
        wr(2'd0, 32'h5); rd(2'd2, 2);

        tag = "R6 ack without run stops and keeps pending";
        wr(2'd0, 32'h4); rd(2'd2, 1); rd(2'd0, 1);

        tag = "R6 ack with run after enable clears";
        wr(2'd0, 32'h3); wr(2'd0, 32'h7); rd(2'd2, 2);

        tag = "R5 ien write while stopped ignored";
        wr(2'd0, 32'h0); wr(2'd0, 32'h0); wr(2'd0, 32'h1); rd(2'd0, 2);

        tag = "R2 stop mid count holds";
        wr(2'd1, 32'd10); rd(2'd1, 3);
        wr(2'd0, 32'h0); rd(2'd1, 4);
        wr(2'd0, 32'h1); rd(2'd1, 12); rd(2'd2, 1);

        tag = "R4 one-shot stays at zero";
        rd(2'd1, 5);
        shutdown();

        for (int k = 1; k <= 5; k++) begin
            tag = $sformatf("R10 ack offset %0d near expiry", k);
            wr(2'd0, 32'h3); wr(2'd1, 32'd3);
            rd(2'd2, k - 1);
            wr(2'd0, 32'h7); rd(2'd2, 3);
            shutdown();
        end

        for (int k = 1; k <= 4; k++) begin
            tag = $sformatf("R11 reload offset %0d near expiry", k);
            wr(2'd0, 32'h3); wr(2'd1, 32'd2);
            rd(2'd1, k - 1);
            wr(2'd1, 32'd7); rd(2'd2, 3); rd(2'd1, 6);
            shutdown();
        end

        tag = "R8 pending visible with ien low";
        wr(2'd0, 32'h1); wr(2'd1, 32'd1); rd(2'd2, 3);
        shutdown();

        tag = "R1 reset mid count";
        wr(2'd0, 32'h3); wr(2'd1, 32'd9); rd(2'd1, 2);
        @(negedge clk); #1; rst = 1'b1;
        rd(2'd1, 2);
        @(negedge clk); #1; rst = 1'b0;
        rd(2'd0, 1); rd(2'd2, 1);

        rd(2'd0, 2);
        finish_run();
    end

endmodule